// File: doc/BRIEF.md
# Quad-SPI Instruction Frame Sequencer

This block runs one serial-memory instruction frame on a four-lane SPI bus. A frame has up to five phases, always in the order instruction, address, option, dummy, data. Each phase is switched on by its own bit of a frame-configuration word. A three-bit width code picks one of seven fixed lane-count combinations for the command, address and data phases. The instruction-code word carries the opcode and an option byte, and the address word carries a 24-bit or 32-bit address.

A `start` pulse in idle latches the three words and the read/write direction, then drops chip-select. Phases that need no data run to completion by themselves. In the data phase, bytes move through a valid/ready transmit handshake for writes, or come out as `rx_data` with an `rx_valid` pulse for reads. The frame stays open, with chip-select low, until `last_xfer` is requested. Each serial clock period takes two system clocks: the serial clock is low on the first and high on the second.

Two sticky status flags report progress. Status bit 10 marks the end of the command phases, and status bit 8 marks the rise of chip-select. `cmd_done` is high while both are set, and a `status_rd` strobe clears them.

Top module: `qspi_frame_seq`

## Requirements
- R1: Width code `frame_cfg[2:0]` sets the command/address/data lane counts: 0→1/1/1, 1→1/1/2, 2→1/1/4, 3→1/2/2, 4→1/4/4, 5→2/2/2, 6→4/4/4. Code 7 behaves as 1/1/1.
- R2: Phase enables are `frame_cfg` bit 4 (instruction), bit 5 (address), bit 6 (option) and bit 7 (data). The dummy phase runs when `frame_cfg[20:16]` is non-zero. The enabled phases run in the order instruction, address, option, dummy, data, and a disabled phase gives no serial clocks.
- R3: Each phase is sent most significant bit first, with one group of bits per serial clock, sampled by the memory on the rising edge of `sck`. On one lane the bit goes out on `io_out[0]`. On two lanes the bits go on `io_out[1:0]`, and on four lanes on `io_out[3:0]`. The higher-order bit is always on the higher lane. `io_oe` is 0001, 0011 or 1111 while driving.
- R4: The opcode is `inst_word[7:0]`, sent on the command lanes. `frame_cfg[10]` set sends all 32 bits of `addr_word`, and clear sends `addr_word[23:0]`, both on the address lanes.
- R5: `frame_cfg[9:8]` codes 0..3 set an option length of 1, 2, 4 or 8 bits. The option sends that many low-order bits of `inst_word[23:16]` on the address lanes. A phase shorter than the lane count takes one clock, with its bits on the top lanes and zeros below.
- R6: The dummy phase gives exactly `frame_cfg[20:16]` serial clocks with `io_oe` = 0000 and `io_out` = 0000.
- R7: In a read frame (`rd_frame`=1 at start), the data phase keeps `io_oe` = 0000. It samples data lanes (single lane: `io_in[1]`; two lanes: `io_in[1:0]`; four lanes: `io_in[3:0]`) on the rising edge of `sck`, highest lane first. Each byte appears on `rx_data` with a one-cycle `rx_valid`.
- R8: In a write frame, a byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high, and is then sent on the data lanes. `tx_ready` is high only between bytes, while no last-transfer request is pending.
- R9: With the data phase enabled, chip-select stays low and `sck` stays low between bytes until `last_xfer` is requested. The frame then closes after the byte in flight. A frame without a data phase closes on its own. A `last_xfer` pulse while idle has no effect on the next frame.
- R10: Status bit 10 is set when the last non-data phase ends, and status bit 8 is set when `cs_n` rises. `cmd_done` is high when both are set. A `status_rd` pulse clears both, but a flag being set in the same cycle wins. All other status bits read 0.
- R11: A `start` pulse while a frame is open is ignored.
- R12: After reset, `cs_n`=1, `sck`=0, `io_oe`=0, `tx_ready`=0, `rx_valid`=0 and `status`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (idle only) |
| frame_cfg | input | 32 | Width code, phase enables, option length, address length, dummy count |
| inst_word | input | 32 | Opcode in [7:0], option byte in [23:16] |
| addr_word | input | 32 | Address |
| rd_frame | input | 1 | Data phase direction, 1 = read |
| tx_data | input | 8 | Write byte |
| tx_valid | input | 1 | Write byte offered |
| tx_ready | output | 1 | Write byte taken this cycle if valid |
| rx_data | output | 8 | Read byte |
| rx_valid | output | 1 | One-cycle pulse with each read byte |
| last_xfer | input | 1 | Request to close the frame |
| status_rd | input | 1 | Status read strobe, clears sticky flags |
| status | output | 11 | Bit 10 instruction end, bit 8 chip-select rise |
| cmd_done | output | 1 | Both completion flags set |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip-select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
A wrong phase selection or a wrong load of the shift register shows up at once in the stream of lane values on the next rising serial edge. A missing or extra step shows up as a changed symbol count before chip-select rises. A wrong lane map or input sample corrupts `rx_data` at the end of the first read byte, within eight serial clocks. A bad frame-close or flag-update path shows up the cycle after the byte boundary, as `cs_n` staying low or as `status` bits disagreeing with the phase just finished.

// File: rtl/qspi_frame_seq.sv
module qspi_frame_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] frame_cfg,
  input  logic [31:0] inst_word,
  input  logic [31:0] addr_word,
  input  logic        rd_frame,
  input  logic [7:0]  tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  input  logic        last_xfer,
  input  logic        status_rd,
  output logic [10:0] status,
  output logic        cmd_done,
  output logic        sck,
  output logic        cs_n,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in
);

  typedef enum logic [2:0] {
    S_IDLE, S_INST, S_ADDR, S_OPT, S_DUM, S_GAP, S_DATA, S_END
  } st_t;

  st_t         st, tgt;
  logic [31:0] cfg_q, ins_q, adr_q, cf, ins, adr;
  logic        rd_q, sck_q, cs_q, lp_q, ie_q, cr_q, rxv_q;
  logic [31:0] sh, ld_sh;
  logic [5:0]  rem, ld_rem, optl;
  logic [7:0]  rx_sh, rxd_q;
  logic [2:0]  n;
  logic        lp, drive;

  function automatic st_t after(input st_t p, input logic [31:0] c);
    if (p < S_INST && c[4]) return S_INST;
    if (p < S_ADDR && c[5]) return S_ADDR;
    if (p < S_OPT && c[6]) return S_OPT;
    if (p < S_DUM && c[20:16] != 5'd0) return S_DUM;
    if (p < S_GAP && c[7]) return S_GAP;
    return S_END;
  endfunction

  function automatic logic [2:0] lanes_of(input st_t p, input logic [2:0] m);
    logic [2:0] lc, la, ld;
    lc = (m == 3'd5) ? 3'd2 : (m == 3'd6) ? 3'd4 : 3'd1;
    la = (m == 3'd3 || m == 3'd5) ? 3'd2 : (m == 3'd4 || m == 3'd6) ? 3'd4 : 3'd1;
    ld = (m == 3'd1 || m == 3'd3 || m == 3'd5) ? 3'd2 :
         (m == 3'd2 || m == 3'd4 || m == 3'd6) ? 3'd4 : 3'd1;
    case (p)
      S_INST:         return lc;
      S_ADDR, S_OPT:  return la;
      S_DATA:         return ld;
      default:        return 3'd1;
    endcase
  endfunction

  assign cf  = (st == S_IDLE) ? frame_cfg : cfg_q;
  assign ins = (st == S_IDLE) ? inst_word : ins_q;
  assign adr = (st == S_IDLE) ? addr_word : adr_q;
  assign n   = lanes_of(st, cfg_q[2:0]);
  assign tgt = after(st, cf);
  assign optl = 6'd1 << cf[9:8];

  always_comb begin
    ld_sh  = 32'd0;
    ld_rem = 6'd0;
    case (tgt)
      S_INST: begin ld_sh = {ins[7:0], 24'd0}; ld_rem = 6'd8; end
      S_ADDR: begin
        ld_sh  = cf[10] ? adr : {adr[23:0], 8'd0};
        ld_rem = cf[10] ? 6'd32 : 6'd24;
      end
      S_OPT:  begin ld_sh = {ins[23:16], 24'd0} << (6'd8 - optl); ld_rem = optl; end
      S_DUM:  ld_rem = {1'b0, cf[20:16]};
      default: ;
    endcase
  end

  assign lp       = lp_q | last_xfer;
  assign tx_ready = (st == S_GAP) && !lp && !rd_q;
  assign drive    = (st == S_INST) || (st == S_ADDR) || (st == S_OPT) ||
                    (st == S_DATA && !rd_q);
  assign io_oe    = !drive ? 4'b0000 : (n == 3'd4) ? 4'b1111 :
                    (n == 3'd2) ? 4'b0011 : 4'b0001;
  assign io_out   = io_oe & ((n == 3'd4) ? sh[31:28] :
                    (n == 3'd2) ? {2'b00, sh[31:30]} : {3'b000, sh[31]});
  assign sck      = sck_q;
  assign cs_n     = !cs_q;
  assign rx_data  = rxd_q;
  assign rx_valid = rxv_q;
  assign status   = {ie_q, 1'b0, cr_q, 8'd0};
  assign cmd_done = ie_q & cr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cfg_q <= '0; ins_q <= '0; adr_q <= '0; rd_q <= 1'b0;
      sh <= '0; rem <= '0; rx_sh <= '0; rxd_q <= '0;
      sck_q <= 1'b0; cs_q <= 1'b0; lp_q <= 1'b0;
      ie_q <= 1'b0; cr_q <= 1'b0; rxv_q <= 1'b0;
    end else begin
      rxv_q <= 1'b0;
      if (status_rd) begin
        ie_q <= 1'b0;
        cr_q <= 1'b0;
      end
      if (last_xfer && st != S_IDLE) lp_q <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          cfg_q <= frame_cfg; ins_q <= inst_word; adr_q <= addr_word;
          rd_q <= rd_frame;
          cs_q <= 1'b1;
          st <= tgt; sh <= ld_sh; rem <= ld_rem;
          if (tgt == S_GAP || tgt == S_END) ie_q <= 1'b1;
        end
        S_INST, S_ADDR, S_OPT, S_DUM, S_DATA: begin
          if (!sck_q) begin
            sck_q <= 1'b1;
            if (st == S_DATA && rd_q)
              rx_sh <= (n == 3'd4) ? {rx_sh[3:0], io_in} :
                       (n == 3'd2) ? {rx_sh[5:0], io_in[1:0]} : {rx_sh[6:0], io_in[1]};
          end else begin
            sck_q <= 1'b0;
            if (rem > {3'd0, n}) begin
              sh  <= sh << n;
              rem <= rem - {3'd0, n};
            end else if (st == S_DATA) begin
              st <= S_GAP;
              if (rd_q) begin
                rxd_q <= rx_sh;
                rxv_q <= 1'b1;
              end
            end else begin
              st <= tgt; sh <= ld_sh; rem <= ld_rem;
              if (tgt == S_GAP || tgt == S_END) ie_q <= 1'b1;
            end
          end
        end
        S_GAP: begin
          if (lp) st <= S_END;
          else if (rd_q) begin
            st <= S_DATA; rem <= 6'd8;
          end else if (tx_valid) begin
            st <= S_DATA; rem <= 6'd8; sh <= {tx_data, 24'd0};
          end
        end
        default: begin
          cs_q <= 1'b0;
          cr_q <= 1'b1;
          lp_q <= 1'b0;
          st <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/qspi_frame_seq_chk.sv
module qspi_frame_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        status_rd,
  input logic        sck,
  input logic        cs_n,
  input logic [3:0]  io_oe,
  input logic        tx_ready,
  input logic        rx_valid,
  input logic [10:0] status
);

  a_r3_oe_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000 || io_oe == 4'b0001 || io_oe == 4'b0011 || io_oe == 4'b1111));

  a_r9_sck_idle_high_cs: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  a_r8_tx_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!cs_n && !sck));

  a_r7_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && start) |=> !cs_n);

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> (!status[8] || $rose(cs_n)));

  a_r10_rise_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> status[8]);

endmodule

bind qspi_frame_seq qspi_frame_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .status_rd(status_rd),
  .sck(sck), .cs_n(cs_n), .io_oe(io_oe), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .status(status)
);

// File: tb/tb_qspi_frame_seq.sv
module tb_qspi_frame_seq;
  localparam int CLK_P = 10;
  localparam int NV = 10;

  localparam logic [31:0] V_CFG [NV] = '{32'h0000_0010, 32'h0000_00B0, 32'h0008_00B2,
    32'h0004_03F4, 32'h0000_04B6, 32'h0000_01D5, 32'h0000_0037, 32'h0008_00B1,
    32'h0000_0054, 32'h0000_0080};
  localparam logic [31:0] V_INS [NV] = '{32'h06, 32'h02, 32'h6B, 32'h00A5_00EB, 32'h12,
    32'h0002_003B, 32'h05, 32'h3B, 32'h0001_0077, 32'h00};
  localparam logic [31:0] V_ADR [NV] = '{32'h0, 32'h0012_3456, 32'h00AB_CDEF, 32'h0000_1000,
    32'h89AB_CDEF, 32'h0, 32'h0000_ABCD, 32'h0000_0100, 32'h0, 32'h0};
  localparam logic [7:0]  V_WD  [NV] = '{8'h00, 8'hA5, 8'h00, 8'h00, 8'h3C, 8'h00, 8'h00,
    8'h00, 8'h00, 8'hC3};
  localparam logic        V_RD  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
    1'b0, 1'b0};
  localparam string       V_TAG [NV] = '{"R2 R9", "R8 R4", "R1 R6 R7", "R5 R3", "R4 R1",
    "R5 R1", "R1", "R1 R7", "R5", "R2 R8"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, rd_frame = 0, tx_valid = 0, last_xfer = 0, status_rd = 0;
  logic [31:0] frame_cfg = 0, inst_word = 0, addr_word = 0;
  logic [7:0] tx_data = 0, rx_data;
  logic tx_ready, rx_valid, cmd_done, sck, cs_n;
  logic [10:0] status;
  logic [3:0] io_out, io_oe, io_in = 4'h3;

  int checks = 0, fails = 0, ncap = 0, nexp = 0, rx_cnt = 0, cyc = 0;
  logic [3:0] cap_out [256], cap_oe [256], cap_in [256], exp_out [256], exp_oe [256];
  logic [7:0] rx_got;
  logic sck_d = 1'b0;

  qspi_frame_seq dut (.*);

  always #(CLK_P / 2) clk = ~clk;

  always @(negedge clk) begin
    if (sck && !sck_d && ncap < 256) begin
      cap_out[ncap] = io_out; cap_oe[ncap] = io_oe; cap_in[ncap] = io_in;
      ncap = ncap + 1;
    end
    if (!sck && sck_d) io_in = io_in * 4'd5 + 4'd3;
    if (rx_valid) begin rx_got = rx_data; rx_cnt = rx_cnt + 1; end
    sck_d = sck;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL R9 watchdog: actual=hung expected=frame closed");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lanes(input int which, input logic [2:0] m);
    if (which == 0) return (m == 5) ? 2 : (m == 6) ? 4 : 1;
    if (which == 1) return (m == 3 || m == 5) ? 2 : (m == 4 || m == 6) ? 4 : 1;
    return (m == 1 || m == 3 || m == 5) ? 2 : (m == 2 || m == 4 || m == 6) ? 4 : 1;
  endfunction

  task automatic add_ph(input logic [31:0] v, input int len, input int n, input bit drv);
    int steps;
    steps = (len + n - 1) / n;
    for (int s = 0; s < steps; s++) begin
      logic [3:0] o;
      o = 4'd0;
      for (int j = 0; j < n; j++) begin
        int b;
        b = len - 1 - s * n - j;
        if (b >= 0 && drv) o[n - 1 - j] = v[b];
      end
      exp_out[nexp] = o;
      exp_oe[nexp] = !drv ? 4'd0 : (n == 1) ? 4'd1 : (n == 2) ? 4'd3 : 4'hF;
      nexp = nexp + 1;
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic cmp_stream(input string tag);
    int bad;
    bad = -1;
    chk(ncap == nexp, tag, ncap, nexp);
    for (int k = 0; k < nexp && k < ncap; k++)
      if (bad < 0 && (cap_out[k] !== exp_out[k] || cap_oe[k] !== exp_oe[k])) bad = k;
    if (bad >= 0) chk(0, tag, {cap_oe[bad], cap_out[bad]}, {exp_oe[bad], exp_out[bad]});
    else chk(1, tag, 0, 0);
  endtask

  task automatic run_vec(input int i);
    logic [31:0] c, in, ad;
    int cl, al, dl, nd, base, L;
    logic [7:0] exp_rx;
    c = V_CFG[i]; in = V_INS[i]; ad = V_ADR[i];
    cl = lanes(0, c[2:0]); al = lanes(1, c[2:0]); dl = lanes(2, c[2:0]);
    nd = int'(c[20:16]);
    nexp = 0;
    if (c[4]) add_ph({24'd0, in[7:0]}, 8, cl, 1);
    if (c[5]) add_ph(c[10] ? ad : {8'd0, ad[23:0]}, c[10] ? 32 : 24, al, 1);
    if (c[6]) begin
      L = 1 << c[9:8];
      add_ph({24'd0, in[23:16]} & ((32'd1 << L) - 1), L, al, 1);
    end
    if (nd > 0) add_ph(0, nd, 1, 0);
    base = nexp;
    if (c[7]) add_ph({24'd0, V_WD[i]}, 8, dl, !V_RD[i]);
    ncap = 0; rx_cnt = 0;
    frame_cfg = c; inst_word = in; addr_word = ad; rd_frame = V_RD[i];
    if (c[7] && !V_RD[i]) begin tx_valid = 1'b1; tx_data = V_WD[i]; end
    pulse(start);
    if (c[7]) begin
      while (ncap <= base) @(negedge clk);
      tx_valid = 1'b0;
      pulse(last_xfer);
    end
    while (!cs_n) @(negedge clk);
    @(negedge clk);
    cmp_stream(V_TAG[i]);
    if (c[7] && V_RD[i]) begin
      exp_rx = 8'd0;
      for (int k = base; k < nexp; k++)
        exp_rx = (dl == 1) ? {exp_rx[6:0], cap_in[k][1]} :
                 (dl == 2) ? {exp_rx[5:0], cap_in[k][1:0]} : {exp_rx[3:0], cap_in[k]};
      chk(rx_cnt == 1 && rx_got == exp_rx, "R7 read byte", {rx_cnt[23:0], rx_got}, {24'd1, exp_rx});
    end
    chk(status == 11'h500 && cmd_done, "R10 flags at close", {status, cmd_done}, {11'h500, 1'b1});
    pulse(status_rd);
    chk(status == 11'h000 && !cmd_done, "R10 read clears", {status, cmd_done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0, "R12 reset cs/sck", {cs_n, sck}, 2'b10);
    chk(io_oe === 4'd0 && tx_ready === 1'b0 && rx_valid === 1'b0, "R12 reset outputs",
        {io_oe, tx_ready, rx_valid}, 0);
    chk(status === 11'd0 && cmd_done === 1'b0, "R12 reset status", {status, cmd_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    pulse(last_xfer);   // R9: request while idle must not close the next frame early
    for (int i = 0; i < NV; i++) run_vec(i);

    // R11 / R10 / R9: frame waiting between bytes
    nexp = 0;
    add_ph(32'h9F, 8, 1, 1);
    add_ph(32'h5A, 8, 1, 1);
    ncap = 0;
    frame_cfg = 32'h90; inst_word = 32'h9F; addr_word = 0; rd_frame = 0;
    pulse(start);
    while (ncap < 8) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(cs_n == 1'b0 && sck == 1'b0, "R9 held open", {cs_n, sck}, 2'b00);
    chk(status == 11'h400, "R10 instruction end before close", status, 11'h400);
    chk(tx_ready == 1'b1, "R8 ready between bytes", tx_ready, 1);
    frame_cfg = 32'h10; inst_word = 32'hFF;
    pulse(start);
    repeat (4) @(negedge clk);
    chk(ncap == 8 && cs_n == 1'b0, "R11 start ignored", ncap, 8);
    pulse(status_rd);
    chk(status == 11'h000, "R10 clear mid-frame", status, 0);
    tx_data = 8'h5A; tx_valid = 1'b1;
    while (ncap <= 8) @(negedge clk);
    tx_valid = 1'b0;
    pulse(last_xfer);
    while (!cs_n) @(negedge clk);
    @(negedge clk);
    cmp_stream("R11 R8");
    chk(status == 11'h100 && !cmd_done, "R10 rise only", {status, cmd_done}, {11'h100, 1'b0});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule